// File: doc/BRIEF.md
# Record Identifier Slot Directory

This block keeps a table that maps numbered storage slots to 64-bit record identifiers. Alongside the table it keeps a running count of valid records. A value of zero in a slot marks that slot as free. The slots below a computed first index hold a storage header, so no record is ever placed there. The table lives in an internal RAM and has one entry per slot.

A requester starts one operation at a time with a single-cycle start strobe. The five operations are:
- look up an identifier;
- find the first free slot;
- insert an identifier, which overwrites the entry if it is already present and otherwise takes the first free slot;
- clear an identifier;
- step an iterator through the stored identifiers.

The iterator keeps a cursor between calls. The block scans one slot per clock. It holds `busy` while it scans. It then raises `done` for one cycle, together with a slot index, a status byte and, for the iterator, the identifier found. A slot index of 0 always means "no slot".

Top module: `slot_dir`

## Requirements
- R1: After synchronous reset `busy`, `done` and `rec_count` are 0 and every slot reads as free.
- R2: Inserting an identifier that is not present writes it into the lowest free slot at or above the first index. It returns that slot with status 0x00 and raises `rec_count` by one.
- R3: Inserting an identifier that is already present returns its existing slot with status 0x00 and leaves `rec_count` unchanged.
- R4: An insert with identifier 0 or all-ones returns status 0x03 at once. An insert while no slot is free returns slot 0 with status 0x01. In both cases `rec_count` does not change.
- R5: A lookup returns the slot that holds the identifier with status 0x00, or slot 0 with status 0x05 when it is absent. A lookup of identifier 0 completes in the start cycle with slot 0 and status 0x05.
- R6: A lookup (including the lookup phase of clear and insert) uses one cycle per step. A step ends the scan with "absent" when the pointer has reached the last slot or when the number of nonzero entries passed equals `rec_count`. Otherwise it ends with "found" on a match, or moves on to the next slot.
- R7: Clearing a present identifier writes 0 to its slot, returns that slot with status 0x00 and lowers `rec_count` by one. An absent identifier gives status 0x05. Identifier 0 or all-ones gives status 0x03 at once.
- R8: Find-free returns the lowest slot at or above the first index that holds 0, with status 0x00. It returns slot 0 with status 0x01 when every slot is taken. It costs one cycle per slot visited.
- R9: The iterator starts at the cursor, or at the first index when `iter_first` is set. It returns the next nonzero entry and its slot with status 0x00, and moves the cursor to one past that slot.
- R10: When `rec_count` is 0 (completing in the start cycle) or no further entry exists, the iterator returns the all-ones identifier and slot 0 with status 0x00, and rewinds the cursor to the first index.
- R11: The first index equals (HDR_BYTES + 8*SLOTS) divided by SLOT_BYTES and rounded up. This gives 3 with the defaults. No result slot is ever below it or at or above SLOTS.
- R12: `busy` is high from the cycle after an accepted start until `done`. `done` is a one-cycle pulse during which `busy` is low. A start while `busy` is high is ignored.
- R13: Operation codes on `op` are 0 lookup, 1 find-free, 2 clear, 3 insert and 4 next-identifier. Any other code completes in the start cycle with status 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the operation on `op` |
| op | input | 3 | Operation code |
| id_in | input | ID_W | Identifier operand |
| iter_first | input | 1 | Restart the iterator at the first index |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| res_idx | output | IDX_W | Result slot, 0 for none |
| res_id | output | ID_W | Identifier returned by the iterator, 0 for other operations |
| status | output | 8 | Completion status code |
| rec_count | output | IDX_W | Number of valid records |

## Verification
The assertions take for granted that the requester raises `start` only as a single-cycle pulse. They also assume that `id_in` and `iter_first` are stable at the start edge, and that nobody modifies the table other than through this block's own operations.

The stimulus drives every input on the falling edge and lowers `start` one cycle later. It waits for `done` before it begins the next operation. The only exception is one deliberate start pulse given while a long lookup is busy, which the block must ignore.

The bench's model predicts the latency of each operation from the scan rules and checks `busy` on every cycle of the wait.

// File: rtl/sdir_pkg.sv
// Shared operation codes, status codes and controller states for the
// slot directory. Assumes an 8-bit status field.
package sdir_pkg;
    typedef enum logic [2:0] {
        OP_LOOKUP = 3'd0,
        OP_FREE   = 3'd1,
        OP_CLEAR  = 3'd2,
        OP_INSERT = 3'd3,
        OP_NEXT   = 3'd4
    } sdir_op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOOK,
        S_FREE,
        S_ITER
    } sdir_state_e;

    localparam logic [7:0] ST_OK     = 8'h00;
    localparam logic [7:0] ST_FULL   = 8'h01;
    localparam logic [7:0] ST_BAD    = 8'h03;
    localparam logic [7:0] ST_ABSENT = 8'h05;
endpackage

// File: rtl/sdir_map_ram.sv
// Slot map storage: one identifier register per slot.
// It has a single write port and an asynchronous read port.
// A read at an index outside the table returns zero.
// Assumes that all writes come from the controller.
module sdir_map_ram #(
    parameter int ID_W  = 64,
    parameter int SLOTS = 16,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ID_W-1:0]  rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ID_W-1:0]  wr_data
);
    localparam int AW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [IDX_W-1:0] LAST_I = IDX_W'(SLOTS);

    logic [ID_W-1:0] mem [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Holds one slot entry; reset marks the slot as free.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                mem[g] <= wr_data;
        end
    end

    // Reads the addressed slot, or zero when the index is past the table.
    always_comb begin
        rd_data = '0;
        if (rd_idx < LAST_I)
            rd_data = mem[rd_idx[AW-1:0]];
    end

    AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < LAST_I)); // R11
endmodule

// File: rtl/sdir_ctrl.sv
// Scan controller for the slot directory. It accepts one operation at a time,
// walks the slot map one entry per cycle, keeps the record count and the
// iterator cursor, and reports each result on a one-cycle done pulse.
// Assumes that start is a one-cycle pulse and that the operands are valid with it.
module sdir_ctrl
    import sdir_pkg::*;
#(
    parameter int ID_W  = 64,
    parameter int SLOTS = 16,
    parameter int FIRST = 3,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [ID_W-1:0]  id_in,
    input  logic             iter_first,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] res_idx,
    output logic [ID_W-1:0]  res_id,
    output logic [7:0]       status,
    output logic [IDX_W-1:0] rec_count,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [ID_W-1:0]  rd_data,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [ID_W-1:0]  wr_data
);
    localparam logic [IDX_W-1:0] FIRST_I = IDX_W'(FIRST);
    localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(SLOTS);
    localparam logic [IDX_W-1:0] CAP_I   = IDX_W'(SLOTS - FIRST);
    localparam logic [ID_W-1:0]  ALL1    = {ID_W{1'b1}};

    sdir_state_e      state_q;
    sdir_op_e         op_q;
    sdir_op_e         op_in;
    logic [ID_W-1:0]  id_q;
    logic [IDX_W-1:0] ptr_q, seen_q, cnt_q, cur_q, idx_q;
    logic [ID_W-1:0]  rid_q;
    logic [7:0]       st_q;
    logic             done_q;
    logic             at_end, look_stop, hit, empty, id_bad;

    assign op_in = sdir_op_e'(op);

    // Decodes the current scan step from the pointer and the entry read.
    always_comb begin
        at_end    = (ptr_q >= LAST_I);
        look_stop = at_end || (seen_q == cnt_q);
        hit       = (rd_data == id_q);
        empty     = (rd_data == '0);
        id_bad    = (id_in == '0) || (id_in == ALL1);
    end

    // Drives the map write for a clear hit or for an insert into a free slot.
    always_comb begin
        wr_en   = ((state_q == S_LOOK) && !look_stop && hit && (op_q == OP_CLEAR)) ||
                  ((state_q == S_FREE) && !at_end && empty && (op_q == OP_INSERT));
        wr_idx  = ptr_q;
        wr_data = (op_q == OP_CLEAR) ? '0 : id_q;
        rd_idx  = ptr_q;
    end

    // Sequences the operations and holds the results, count and cursor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_LOOKUP;
            id_q    <= '0;
            ptr_q   <= FIRST_I;
            seen_q  <= '0;
            cnt_q   <= '0;
            cur_q   <= FIRST_I;
            idx_q   <= '0;
            rid_q   <= '0;
            st_q    <= ST_OK;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        op_q   <= op_in;
                        id_q   <= id_in;
                        ptr_q  <= FIRST_I;
                        seen_q <= '0;
                        rid_q  <= '0;
                        idx_q  <= '0;
                        case (op_in)
                            OP_LOOKUP: begin
                                if (id_in == '0) begin
                                    st_q   <= ST_ABSENT;
                                    done_q <= 1'b1;
                                end else begin
                                    state_q <= S_LOOK;
                                end
                            end
                            OP_CLEAR, OP_INSERT: begin
                                if (id_bad) begin
                                    st_q   <= ST_BAD;
                                    done_q <= 1'b1;
                                end else begin
                                    state_q <= S_LOOK;
                                end
                            end
                            OP_FREE: state_q <= S_FREE;
                            OP_NEXT: begin
                                if (cnt_q == '0) begin
                                    rid_q  <= ALL1;
                                    cur_q  <= FIRST_I;
                                    st_q   <= ST_OK;
                                    done_q <= 1'b1;
                                end else begin
                                    ptr_q   <= iter_first ? FIRST_I : cur_q;
                                    state_q <= S_ITER;
                                end
                            end
                            default: begin
                                st_q   <= ST_BAD;
                                done_q <= 1'b1;
                            end
                        endcase
                    end
                end
                S_LOOK: begin
                    if (look_stop) begin
                        if (op_q == OP_INSERT) begin
                            ptr_q   <= FIRST_I;
                            state_q <= S_FREE;
                        end else begin
                            idx_q   <= '0;
                            st_q    <= ST_ABSENT;
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end
                    end else if (hit) begin
                        if (op_q == OP_CLEAR)
                            cnt_q <= cnt_q - 1'b1;
                        idx_q   <= ptr_q;
                        st_q    <= ST_OK;
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end else begin
                        ptr_q  <= ptr_q + 1'b1;
                        seen_q <= seen_q + {{(IDX_W-1){1'b0}}, ~empty};
                    end
                end
                S_FREE: begin
                    if (at_end) begin
                        idx_q   <= '0;
                        st_q    <= ST_FULL;
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end else if (empty) begin
                        if (op_q == OP_INSERT)
                            cnt_q <= cnt_q + 1'b1;
                        idx_q   <= ptr_q;
                        st_q    <= ST_OK;
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                S_ITER: begin
                    if (at_end) begin
                        rid_q   <= ALL1;
                        idx_q   <= '0;
                        cur_q   <= FIRST_I;
                        st_q    <= ST_OK;
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end else if (!empty) begin
                        rid_q   <= rd_data;
                        idx_q   <= ptr_q;
                        cur_q   <= ptr_q + 1'b1;
                        st_q    <= ST_OK;
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != S_IDLE);
    assign done      = done_q;
    assign res_idx   = idx_q;
    assign res_id    = rid_q;
    assign status    = st_q;
    assign rec_count = cnt_q;

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy); // R12
    AST_IDX_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && (idx_q != '0)) |-> ((idx_q >= FIRST_I) && (idx_q < LAST_I))); // R11
    AST_MISS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && (st_q != ST_OK)) |-> (idx_q == '0)); // R5
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) ||
        (cnt_q == $past(cnt_q) - 1'b1)); // R2
    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP_I); // R4
    AST_END_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && (rid_q == ALL1)) |-> ((idx_q == '0) && (cur_q == FIRST_I))); // R10
endmodule

// File: rtl/slot_dir.sv
// Record identifier slot directory top. It derives the first usable slot from
// the header size and connects the scan controller to the slot map storage.
// Assumes that SLOTS fits in IDX_W bits and that the header leaves at least one slot.
module slot_dir #(
    parameter int ID_W       = 64,
    parameter int SLOTS      = 16,
    parameter int SLOT_BYTES = 64,
    parameter int HDR_BYTES  = 24,
    localparam int HDR_TOTAL = HDR_BYTES + 8 * SLOTS,
    localparam int FIRST     = (HDR_TOTAL + SLOT_BYTES - 1) / SLOT_BYTES,
    localparam int IDX_W     = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [ID_W-1:0]  id_in,
    input  logic             iter_first,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] res_idx,
    output logic [ID_W-1:0]  res_id,
    output logic [7:0]       status,
    output logic [IDX_W-1:0] rec_count
);
    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [ID_W-1:0]  rd_data, wr_data;
    logic             wr_en;

    sdir_ctrl #(.ID_W(ID_W), .SLOTS(SLOTS), .FIRST(FIRST), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .id_in(id_in),
        .iter_first(iter_first), .busy(busy), .done(done), .res_idx(res_idx),
        .res_id(res_id), .status(status), .rec_count(rec_count),
        .rd_idx(rd_idx), .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data)
    );

    sdir_map_ram #(.ID_W(ID_W), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );
endmodule

// File: tb/sim_slot_dir.sv
module sim_slot_dir;
    localparam int SLOTS = 16;
    localparam int FIRST = (24 + 8 * SLOTS + 63) / 64;
    localparam logic [63:0] ONES = {64{1'b1}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [63:0] id_in = '0;
    logic        iter_first = 1'b0;
    logic        busy, done;
    logic [4:0]  res_idx, rec_count;
    logic [63:0] res_id;
    logic [7:0]  status;

    int total = 0;
    int bad = 0;

    logic [63:0] m [SLOTS];
    int cnt = 0;
    int cur = FIRST;

    always #10 clk = ~clk;

    slot_dir u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .id_in(id_in),
        .iter_first(iter_first), .busy(busy), .done(done), .res_idx(res_idx),
        .res_id(res_id), .status(status), .rec_count(rec_count)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference lookup walk: returns the slot (0 if absent) and the step count.
    task automatic ref_look(input logic [63:0] id, output int idx, output int lat);
        int p = FIRST;
        int seen = 0;
        idx = 0;
        lat = 0;
        forever begin
            lat++;
            if (p >= SLOTS || seen == cnt) break;
            if (m[p] == id) begin idx = p; break; end
            if (m[p] != 0) seen++;
            p++;
        end
    endtask

    task automatic ref_free(output int idx, output int lat);
        int p = FIRST;
        idx = 0;
        lat = 0;
        forever begin
            lat++;
            if (p >= SLOTS) break;
            if (m[p] == 0) begin idx = p; break; end
            p++;
        end
    endtask

    task automatic model(input int o, input logic [63:0] id, input bit first,
                         output int e_idx, output int e_st, output logic [63:0] e_id,
                         output int e_lat);
        int i2, l2;
        e_idx = 0; e_st = 0; e_id = 0; e_lat = 0;
        case (o)
            0: begin
                if (id == 0) e_st = 5;
                else begin
                    ref_look(id, e_idx, e_lat);
                    e_st = (e_idx == 0) ? 5 : 0;
                end
            end
            1: begin
                ref_free(e_idx, e_lat);
                e_st = (e_idx == 0) ? 1 : 0;
            end
            2: begin
                if (id == 0 || id == ONES) e_st = 3;
                else begin
                    ref_look(id, e_idx, e_lat);
                    if (e_idx == 0) e_st = 5;
                    else begin m[e_idx] = 0; cnt--; end
                end
            end
            3: begin
                if (id == 0 || id == ONES) e_st = 3;
                else begin
                    ref_look(id, e_idx, e_lat);
                    if (e_idx == 0) begin
                        ref_free(i2, l2);
                        e_lat += l2;
                        e_idx = i2;
                        if (i2 == 0) e_st = 1;
                        else begin m[i2] = id; cnt++; end
                    end
                end
            end
            4: begin
                if (first) cur = FIRST;
                if (cnt == 0) begin
                    e_id = ONES; cur = FIRST;
                end else begin
                    int p = cur;
                    forever begin
                        e_lat++;
                        if (p >= SLOTS) begin e_id = ONES; cur = FIRST; break; end
                        if (m[p] != 0) begin e_id = m[p]; e_idx = p; cur = p + 1; break; end
                        p++;
                    end
                end
            end
            default: e_st = 3;
        endcase
    endtask

    // Issues one operation, optionally pokes a start while busy, and checks the outcome.
    task automatic run(input int o, input logic [63:0] id, input bit first,
                       input string tag, input bit inject = 0);
        int e_idx, e_st, e_lat;
        logic [63:0] e_id;
        int lat = 0;
        model(o, id, first, e_idx, e_st, e_id, e_lat);
        @(negedge clk);
        start = 1'b1; op = 3'(o); id_in = id; iter_first = first;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 100) begin
            chk(busy == 1'b1, {tag, " busy during scan (R12)"}, busy, 1);
            if (inject && lat == 0) begin
                start = 1'b1; op = 3'd2; id_in = 64'h1111;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk(lat == e_lat, {tag, " latency"}, lat, e_lat);
        chk(res_idx == 5'(e_idx), {tag, " slot"}, res_idx, e_idx);
        chk(status == 8'(e_st), {tag, " status"}, status, e_st);
        chk(res_id == e_id, {tag, " identifier"}, res_id, e_id);
        chk(rec_count == 5'(cnt), {tag, " count"}, rec_count, cnt);
        chk(busy == 1'b0, {tag, " idle at done (R12)"}, busy, 0);
        @(negedge clk);
        chk(done == 1'b0, {tag, " single done pulse (R12)"}, done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R12 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < SLOTS; i++) m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(rec_count == 0, "R1 count after reset", rec_count, 0);
        run(4, 0, 1'b1, "R10 iterate on empty");
        run(0, 64'h55, 1'b0, "R6 lookup on empty");
        run(1, 0, 1'b0, "R8 free on empty");
        chk(res_idx == 5'd3, "R11 first index", res_idx, 3);
        run(3, 64'h1111, 1'b0, "R2 insert A");
        chk(res_idx == 5'd3, "R11 insert lands at first index", res_idx, 3);
        run(3, 64'h2222, 1'b0, "R2 insert B");
        run(3, 64'h3333, 1'b0, "R2 insert C");
        run(0, 64'h2222, 1'b0, "R5 lookup B");
        run(0, 64'h0, 1'b0, "R5 lookup zero");
        run(0, 64'h9999, 1'b0, "R6 R12 lookup absent with start while busy", 1'b1);
        run(0, 64'h1111, 1'b0, "R12 A untouched by ignored start");
        run(3, 64'h2222, 1'b0, "R3 overwrite B");
        run(2, 64'h2222, 1'b0, "R7 clear B");
        run(2, 64'h2222, 1'b0, "R7 clear absent B");
        run(2, 64'h0, 1'b0, "R7 clear zero");
        run(2, ONES, 1'b0, "R7 clear all-ones");
        run(3, 64'h0, 1'b0, "R4 insert zero");
        run(3, ONES, 1'b0, "R4 insert all-ones");
        run(1, 0, 1'b0, "R8 free after clear");
        run(0, 64'h3333, 1'b0, "R6 lookup past hole");
        run(4, 0, 1'b1, "R9 iterate first");
        run(4, 0, 1'b0, "R9 iterate next");
        run(4, 0, 1'b0, "R10 iterate end");
        run(4, 0, 1'b0, "R10 iterate after rewind");
        run(7, 64'h1, 1'b0, "R13 unknown op");
        for (int k = 0; k < 11; k++) run(3, 64'h100 + 64'(k), 1'b0, "R2 fill");
        run(3, 64'h7777, 1'b0, "R4 insert when full");
        run(1, 0, 1'b0, "R8 free when full");
        run(0, 64'h10a, 1'b0, "R6 lookup deepest");
        run(4, 0, 1'b1, "R9 iterate full first");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule